// File: doc/BRIEF.md
# Comma Aligner with Alignment Lock

This block sits right after a deserializer. Each clock it receives one 10-bit group, and that group may start anywhere inside a transmitted 8b/10b symbol. The block searches for the comma carried by the K28.5 control character, and it accepts either running-disparity form. When it finds one, it moves its barrel shifter to that bit offset so that every recovered symbol begins on its true boundary. The aligned symbols are paired into 20-bit words, and each half of a word feeds its own downstream decoder. The pairing is chosen so that a K28.5 always opens a word.

The block tracks whether the link is established. A link is established by a few idle words, or by one word that the decoders report as valid data. Once the link is up and a comma arrives on the boundary already in use, realignment is frozen. From then on, a comma that appears at a wrong position, for example one produced by a bit error, cannot move the boundary. Only an external loss-of-sync pulse opens realignment again. The same pulse drops the link status.

Top module: `comma_aligner`

## Requirements
- R1: A comma is the 7-bit run 0011111 or 1100000 in arrival order. In the 20-bit window {current group, previous group}, where bit 0 of the previous group arrived first, a hit at offset k (0..9) means window bits k..k+6, read as a value with bit k as the LSB, equal 7'h7C or 7'h03. When several offsets hit, the lowest one wins.
- R2: Once aligned at offset k, each symbol is made of ten consecutive window bits starting at k, and the earliest bit lands in bit 0. The first symbol of a pair is placed in wordOut[9:0] and the second in wordOut[19:10].
- R3: A realigning comma always becomes the first symbol of a word. In the cycle a realignment is taken, no word is emitted. Apart from that, wordValid is high in every second cycle.
- R4: An idle word has wordOut[9:0] equal to 10'h17C or 10'h283, which are K28.5 in its two disparities. After the third idle word counted since the last realignment or loss-of-sync, linkUp goes high in the next cycle.
- R5: A single non-idle word shown while codeValid == 2'b11 raises linkUp in the next cycle.
- R6: A comma is proper when it sits at the current offset and would open a word. A proper comma that arrives while linkUp is high sets alignLocked in the next cycle. While alignLocked is high, no comma changes the boundary or the pairing.
- R7: A lossSync pulse clears alignLocked and linkUp in the next cycle and restarts the idle count. After that, the next comma that is not proper realigns the block.
- R8: A realignment taken while unlocked clears linkUp and the idle count.
- R9: Synchronous reset leaves wordValid, linkUp and alignLocked low, wordOut zero and the offset at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst | input | 1 | Synchronous reset, active high |
| rxGroup | input | 10 | Unaligned group from the deserializer, bit 0 arrived first |
| lossSync | input | 1 | Loss-of-synchronization pulse; re-enables alignment |
| codeValid | input | 2 | Per-slot code-valid flags for the word currently on wordOut |
| wordOut | output | 20 | Aligned symbol pair, first symbol in bits 9:0 |
| wordValid | output | 1 | wordOut holds a new pair |
| linkUp | output | 1 | Link established |
| alignLocked | output | 1 | Realignment frozen |

## Verification
The hardest state to reach from the ports is a locked aligner that then receives a comma at a foreign offset. Getting there takes three idle words on one boundary, followed by one more proper comma, before the false comma is injected. The stimulus is a bit queue into which symbols are packed at a chosen bit position. Padding places each K28.5 at the offset wanted and at the pair phase wanted. This lets the bench reach all ten offsets, then plant a false comma two bits off, and then resume on the original pair boundary.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

  // 8b/10b K28.5 in both running disparities, bit 0 = first transmitted bit
  localparam logic [9:0] K285_NEG = 10'h17C;
  localparam logic [9:0] K285_POS = 10'h283;

  // control-to-datapath strobes
  typedef struct packed {
    logic realign;  // take the found offset, restart pairing
    logic hold;     // alignment frozen
  } ctrlStrobe_t;

  function automatic logic isComma(input logic [6:0] bits);
    return (bits == 7'h7C) || (bits == 7'h03);
  endfunction

endpackage

// File: rtl/ca_datapath.sv
module ca_datapath #(
  parameter int SYM_W = 10
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [SYM_W-1:0]                  rxGroup,
  input  comma_align_pkg::ctrlStrobe_t      strobe,
  output logic                              hitValid,
  output logic                              hitProper,
  output logic [2*SYM_W-1:0]                wordOut,
  output logic                              wordValid
);
  localparam int WIN_W   = 2 * SYM_W;
  localparam int OFF_W   = $clog2(SYM_W);
  localparam int COMMA_W = 7;

  logic [SYM_W-1:0] prevGroup;
  logic [WIN_W-1:0] window;
  logic [WIN_W-1:0] winDly;
  logic [SYM_W-1:0] hitVec;
  logic [OFF_W-1:0] hitOffset;
  logic [OFF_W-1:0] offReg;
  logic             phaseReg;
  logic [SYM_W-1:0] firstSym;
  logic [SYM_W-1:0] symNow;
  logic [WIN_W-1:0] wordReg;
  logic             validReg;

  assign window = {rxGroup, prevGroup};

  // comma search over every offset of the window
  for (genvar k = 0; k < SYM_W; k++) begin : g_search
    assign hitVec[k] = comma_align_pkg::isComma(window[k +: COMMA_W]);
  end

  always_comb begin
    hitOffset = '0;
    for (int k = SYM_W - 1; k >= 0; k--) begin
      if (hitVec[k]) hitOffset = OFF_W'(k);
    end
  end

  assign hitValid  = |hitVec;
  assign hitProper = hitValid && (hitOffset == offReg) && phaseReg;

  // barrel shift on the one-cycle delayed window
  assign symNow = winDly[offReg +: SYM_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      prevGroup <= '0;
      winDly    <= '0;
      offReg    <= '0;
      phaseReg  <= 1'b0;
      firstSym  <= '0;
      wordReg   <= '0;
      validReg  <= 1'b0;
    end else begin
      prevGroup <= rxGroup;
      winDly    <= window;
      if (!phaseReg) firstSym <= symNow;
      if (strobe.realign) begin
        offReg   <= hitOffset;
        phaseReg <= 1'b0;
        validReg <= 1'b0;
      end else begin
        phaseReg <= ~phaseReg;
        validReg <= phaseReg;
        if (phaseReg) wordReg <= {symNow, firstSym};
      end
    end
  end

  assign wordOut   = wordReg;
  assign wordValid = validReg;

  // R3: pairs come out every other cycle
  a_r3_alternate: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);
  // R3: no word in the cycle after a realignment is taken
  a_r3_realign_gap: assert property (@(posedge clk) disable iff (rst)
    strobe.realign |=> !wordValid);
  // R6: the boundary does not move while alignment is frozen
  a_r6_hold_offset: assert property (@(posedge clk) disable iff (rst)
    strobe.hold |=> $stable(offReg));

endmodule

// File: rtl/ca_control.sv
module ca_control #(
  parameter int SYM_W      = 10,
  parameter int LINK_IDLES = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          hitValid,
  input  logic                          hitProper,
  input  logic                          lossSync,
  input  logic [SYM_W-1:0]              slotZero,
  input  logic                          wordValid,
  input  logic [1:0]                    codeValid,
  output comma_align_pkg::ctrlStrobe_t  strobe,
  output logic                          linkUp,
  output logic                          alignLocked
);
  localparam int CNT_W = $clog2(LINK_IDLES + 1);

  logic             enReg;
  logic             linkReg;
  logic [CNT_W-1:0] idleCnt;
  logic             realign;
  logic             isIdle;
  logic             isData;

  assign realign = hitValid && enReg && !hitProper && !lossSync;
  assign isIdle  = wordValid && ((slotZero == SYM_W'(comma_align_pkg::K285_NEG)) ||
                                 (slotZero == SYM_W'(comma_align_pkg::K285_POS)));
  assign isData  = wordValid && !isIdle && (&codeValid);

  always_ff @(posedge clk) begin
    if (rst || lossSync) begin
      enReg   <= 1'b1;
      linkReg <= 1'b0;
      idleCnt <= '0;
    end else if (realign) begin
      linkReg <= 1'b0;
      idleCnt <= '0;
    end else begin
      if (enReg && linkReg && hitProper) enReg <= 1'b0;
      if (isIdle && (idleCnt != CNT_W'(LINK_IDLES))) idleCnt <= idleCnt + 1'b1;
      if (isData || (isIdle && (idleCnt == CNT_W'(LINK_IDLES - 1)))) linkReg <= 1'b1;
    end
  end

  assign strobe.realign = realign;
  assign strobe.hold    = !enReg;
  assign linkUp         = linkReg;
  assign alignLocked    = !enReg;

  // R7: loss of sync drops both link and lock
  a_r7_loss_clears: assert property (@(posedge clk) disable iff (rst)
    lossSync |=> (!linkUp && !alignLocked));
  // R6: locking needs an established link
  a_r6_lock_needs_link: assert property (@(posedge clk) disable iff (rst)
    $rose(alignLocked) |-> $past(linkUp));
  // R4/R5: the link only comes up on a received word
  a_r4_link_after_word: assert property (@(posedge clk) disable iff (rst)
    $rose(linkUp) |-> $past(wordValid));

endmodule

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int SYM_W      = 10,
  parameter int LINK_IDLES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SYM_W-1:0]   rxGroup,
  input  logic               lossSync,
  input  logic [1:0]         codeValid,
  output logic [2*SYM_W-1:0] wordOut,
  output logic               wordValid,
  output logic               linkUp,
  output logic               alignLocked
);
  comma_align_pkg::ctrlStrobe_t strobe;
  logic hitValid;
  logic hitProper;

  ca_datapath #(.SYM_W(SYM_W)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .rxGroup   (rxGroup),
    .strobe    (strobe),
    .hitValid  (hitValid),
    .hitProper (hitProper),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );

  ca_control #(.SYM_W(SYM_W), .LINK_IDLES(LINK_IDLES)) u_control (
    .clk         (clk),
    .rst         (rst),
    .hitValid    (hitValid),
    .hitProper   (hitProper),
    .lossSync    (lossSync),
    .slotZero    (wordOut[SYM_W-1:0]),
    .wordValid   (wordValid),
    .codeValid   (codeValid),
    .strobe      (strobe),
    .linkUp      (linkUp),
    .alignLocked (alignLocked)
  );

endmodule

// File: tb/test_comma_aligner.sv
module test_comma_aligner;
  localparam logic [9:0] KN = 10'h17C;
  localparam logic [9:0] KP = 10'h283;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  rxGroup = '0;
  logic        lossSync = 1'b0;
  logic [1:0]  codeValid = 2'b00;
  logic [19:0] wordOut;
  logic        wordValid, linkUp, alignLocked;

  comma_aligner i_comma_aligner (
    .clk(clk), .rst(rst), .rxGroup(rxGroup), .lossSync(lossSync),
    .codeValid(codeValid), .wordOut(wordOut), .wordValid(wordValid),
    .linkUp(linkUp), .alignLocked(alignLocked)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit bitQ[$];
  int pushed = 0;
  bit fillBit = 1'b0;
  int kSlot = 0, kNeg = 0, kPos = 0;
  int anchor = 0;

  // behavioural reference state
  logic [9:0]  mPrev, mFirst;
  logic [19:0] mWinD, mWord, mWin;
  logic [9:0]  mSym;
  int  mOff, mCnt, mHit;
  bit  mPhase, mValid, mEn, mLink, mProper, mRealign, mIdle, mData;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushFill();
    bitQ.push_back(fillBit);
    fillBit = ~fillBit;
    pushed++;
  endtask

  task automatic pushSym(input logic [9:0] s);
    for (int i = 0; i < 10; i++) begin
      bitQ.push_back(s[i]);
      pushed++;
    end
  endtask

  task automatic padTo(input int modv, input int tgt);
    while ((pushed % modv) != tgt) pushFill();
  endtask

  function automatic int maxRun(input logic [9:0] v);
    int best = 1, run = 1;
    for (int i = 1; i < 10; i++) begin
      run = (v[i] == v[i-1]) ? run + 1 : 1;
      if (run > best) best = run;
    end
    return best;
  endfunction

  function automatic logic [9:0] mkData();
    logic [9:0] v;
    do v = 10'($urandom); while (maxRun(v) > 2 || v == KN || v == KP);
    return v;
  endfunction

  task automatic pushPair(input logic [9:0] a, input logic [9:0] b);
    pushSym(a);
    pushSym(b);
  endtask

  task automatic drain(input int extra);
    while (bitQ.size() > 0) @(posedge clk);
    repeat (extra) @(posedge clk);
  endtask

  task automatic pulseLoss();
    @(negedge clk) lossSync = 1'b1;
    @(negedge clk) lossSync = 1'b0;
  endtask

  // group driver: ten queued bits per cycle, filler when short
  always @(negedge clk) begin
    logic [9:0] g;
    while (bitQ.size() < 10) pushFill();
    for (int i = 0; i < 10; i++) g[i] = bitQ.pop_front();
    rxGroup = g;
  end

  // reference model, advanced on every edge
  always @(posedge clk) begin
    if (rst) begin
      mPrev = '0; mWinD = '0; mOff = 0; mPhase = 0; mFirst = '0;
      mWord = '0; mValid = 0; mEn = 1; mLink = 0; mCnt = 0;
    end else begin
      mWin = {rxGroup, mPrev};
      mHit = -1;
      for (int k = 0; k < 10; k++)
        if (mHit < 0 && (mWin[k +: 7] == 7'h7C || mWin[k +: 7] == 7'h03)) mHit = k;
      mProper  = (mHit >= 0) && (mHit == mOff) && mPhase;
      mRealign = (mHit >= 0) && mEn && !mProper && !lossSync;
      mSym     = 10'(mWinD >> mOff);
      mIdle    = mValid && (mWord[9:0] == KN || mWord[9:0] == KP);
      mData    = mValid && !mIdle && (codeValid == 2'b11);
      if (lossSync) begin
        mEn = 1; mLink = 0; mCnt = 0;
      end else if (mRealign) begin
        mLink = 0; mCnt = 0;
      end else begin
        if (mEn && mLink && mProper) mEn = 0;
        if (mData || (mIdle && mCnt == 2)) mLink = 1;
        if (mIdle && mCnt < 3) mCnt++;
      end
      if (mRealign) begin
        if (!mPhase) mFirst = mSym;
        mOff = mHit; mPhase = 0; mValid = 0;
      end else begin
        if (mPhase) mWord = {mSym, mFirst};
        mValid = mPhase;
        if (!mPhase) mFirst = mSym;
        mPhase = ~mPhase;
      end
      mWinD = mWin;
      mPrev = rxGroup;
    end
  end

  // every-cycle comparison and word monitor
  always @(negedge clk) begin
    if (!rst) begin
      check(wordValid == mValid, "R3 wordValid", wordValid, mValid);
      if (mValid) check(wordOut == mWord, "R2 wordOut", wordOut, mWord);
      check(linkUp == mLink, "R4 linkUp", linkUp, mLink);
      check(alignLocked == !mEn, "R6 alignLocked", alignLocked, !mEn);
      if (wordValid && wordOut[9:0] == KN) begin kSlot++; kNeg++; end
      if (wordValid && wordOut[9:0] == KP) begin kSlot++; kPos++; end
    end
  end

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(wordValid == 1'b0, "R9 wordValid after reset", wordValid, 0);
    check(linkUp == 1'b0, "R9 linkUp after reset", linkUp, 0);
    check(alignLocked == 1'b0, "R9 alignLocked after reset", alignLocked, 0);
    check(wordOut == 20'h0, "R9 wordOut after reset", wordOut, 0);

    // every offset, both comma polarities
    for (int s = 0; s < 10; s++) begin
      pulseLoss();
      @(posedge clk);
      kSlot = 0; kNeg = 0; kPos = 0;
      padTo(10, s);
      anchor = pushed % 20;
      for (int p = 0; p < 8; p++) pushPair((p % 2) ? KP : KN, mkData());
      drain(8);
      check(kSlot >= 4, $sformatf("R2 boundary at offset %0d", s), kSlot, 4);
      check(kNeg > 0 && kPos > 0, "R1 both polarities seen", kNeg * 100 + kPos, 1);
      check(linkUp == 1'b1, "R4 link after idles", linkUp, 1);
      check(alignLocked == 1'b1, "R6 locked after proper comma", alignLocked, 1);
    end

    // false comma two bits off while locked
    @(posedge clk);
    padTo(10, (anchor + 2) % 10);
    pushSym(KN);
    padTo(20, anchor);
    kSlot = 0;
    for (int p = 0; p < 6; p++) pushPair(KP, mkData());
    drain(8);
    check(alignLocked == 1'b1, "R6 still locked after false comma", alignLocked, 1);
    check(kSlot >= 4, "R6 boundary held after false comma", kSlot, 4);
    check(linkUp == 1'b1, "R6 link kept", linkUp, 1);

    // loss of sync then a new offset
    pulseLoss();
    check(alignLocked == 1'b0, "R7 lock cleared", alignLocked, 0);
    check(linkUp == 1'b0, "R7 link cleared", linkUp, 0);
    @(posedge clk);
    padTo(10, 4);
    kSlot = 0;
    for (int p = 0; p < 6; p++) pushPair(KN, mkData());
    drain(8);
    check(kSlot >= 3, "R7 realigned at new offset", kSlot, 3);
    check(linkUp == 1'b1, "R7 link re-established", linkUp, 1);

    // idle count: two idles are not enough
    pulseLoss();
    @(posedge clk);
    padTo(10, 1);
    anchor = pushed % 20;
    pushPair(KN, mkData());
    pushPair(KP, mkData());
    for (int p = 0; p < 3; p++) pushPair(mkData(), mkData());
    drain(8);
    check(linkUp == 1'b0, "R4 two idles keep link down", linkUp, 0);
    @(posedge clk);
    padTo(20, anchor);
    pushPair(KN, mkData());
    for (int p = 0; p < 2; p++) pushPair(mkData(), mkData());
    drain(8);
    check(linkUp == 1'b1, "R4 third idle raises link", linkUp, 1);
    check(alignLocked == 1'b0, "R6 no lock without later comma", alignLocked, 0);

    // realignment while unlocked drops the link
    @(posedge clk);
    padTo(10, 7);
    kSlot = 0;
    pushPair(KP, mkData());
    for (int p = 0; p < 2; p++) pushPair(mkData(), mkData());
    drain(8);
    check(linkUp == 1'b0, "R8 realign clears link", linkUp, 0);
    check(kSlot >= 1, "R8 new boundary taken", kSlot, 1);

    // one valid data word brings the link up
    pulseLoss();
    @(negedge clk) codeValid = 2'b11;
    @(posedge clk);
    padTo(10, 3);
    pushPair(KN, mkData());
    for (int p = 0; p < 3; p++) pushPair(mkData(), mkData());
    drain(8);
    check(linkUp == 1'b1, "R5 data word raises link", linkUp, 1);
    check(alignLocked == 1'b0, "R5 single comma gives no lock", alignLocked, 0);
    @(negedge clk) codeValid = 2'b00;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule